// File: doc/BRIEF.md
# Serial-Addressed Multi-Channel Code Latch Bank

This block is the digital core of a multi-channel programmable resistor. A host writes it over a three-wire serial port: a serial clock, an active-low select and a data line. Each frame is eleven bits long. A 3-bit channel address comes first and an 8-bit code follows, and both fields are sent most significant bit first. When select goes high again, the code is written into the one channel latch that the address names. Every channel code is exported to the analog side, where it sets the wiper position.

A serial output repeats each input bit eleven serial clocks later, so several units can share one data line when select stays low for the whole chained transfer. Two level inputs act on all channels at once. An active-low preset forces every code to midscale, and an active-low shutdown raises a per-channel flag while keeping the codes. The serial pins are asynchronous to the system clock. They are sampled through synchronisers, and the system clock must run at least four times faster than the serial clock.

Top module: `serial_code_latch_bank`

## Requirements
- R1: During and after a synchronous active-high reset, every channel code is 0x80, every shutdown flag is 0 and the serial output is 0.
- R2: A frame is eleven bits shifted in on rising serial-clock edges while select is low. Bits 10..8 form the address and bits 7..0 form the code, and both fields are sent MSB first.
- R3: On a rising edge of select, only the addressed channel latch takes the low eight bits of the shift register. All other channels keep their codes.
- R4: Address value k selects channel index k for k < NCH (default NCH = 6, so values 0..5 are valid). Frames addressed to 6 or 7 change no channel.
- R5: Serial-clock edges while select is high do not alter the shift register.
- R6: If select rises after fewer than eleven new bits, the load uses the eleven most recent bits in the register, including bits left over from earlier transfers.
- R7: The serial output presents the bit that entered the shift register eleven serial-clock edges earlier. It updates together with the shift.
- R8: While preset is low, every code is 0x80 and the serial output stage is 0, and this wins over a load in the same cycle. The shift register keeps its contents.
- R9: While shutdown is low, every shutdown flag is 1, the serial output is forced to 1 and all codes are kept. On release, the flags return to 0 and the output shows the stored stage again.
- R10: Every pin action (shift, load, preset, shutdown) shows at the outputs on the third rising system-clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sel_n_i | input | 1 | Serial select, active low |
| sdat_i | input | 1 | Serial data in |
| preset_n_i | input | 1 | Midscale preset, active low |
| shdn_n_i | input | 1 | Shutdown, active low |
| code_o | output | NCH*DATA_W | Channel codes, channel c at bits c*DATA_W upward |
| shdn_o | output | NCH | Per-channel shutdown flags |
| sdat_o | output | 1 | Daisy-chain serial output |

## Verification
Each pin goes through two synchroniser flops and is then acted on at the next edge. A pin change therefore reaches code_o, shdn_o or sdat_o on the third system-clock edge. The only exception is that nothing responds while select is high and the serial clock toggles.

The bench drives pins on falling edges. Its reference model acts on pin samples that are two and three edges old, and it is compared with the outputs on every falling edge. Directed checks wait at least four edges after a serial-clock rise or a select release before they sample. One check samples both just before and just after the third edge following a select release, to pin down the exact latency.

// File: rtl/scl_pkg.sv
package scl_pkg;

  localparam int ADDR_W_DEF = 3;
  localparam int DATA_W_DEF = 8;

  // Raw or synchronised copy of the five asynchronous control pins.
  typedef struct packed {
    logic preset_n;
    logic shdn_n;
    logic sel_n;
    logic sclk;
    logic dat;
  } pins_t;

  // Pin levels while the port is idle: select high, clock low.
  localparam pins_t PINS_IDLE = '{preset_n: 1'b1, shdn_n: 1'b1, sel_n: 1'b1,
                                  sclk: 1'b0, dat: 1'b0};

endpackage

// File: rtl/scl_pin_sync.sv
module scl_pin_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/scl_shift_front.sv
module scl_shift_front #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int FRAME_W = ADDR_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               sel_n_s,
  input  logic               dat_s,
  input  logic               pre_act,
  input  logic               shdn_act,
  output logic               load_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               sdat_o
);

  logic               sclk_d;
  logic               sel_n_d;
  logic               shift_en;
  logic [FRAME_W-1:0] sreg;
  logic               stage_q;

  // One-cycle delayed copies for edge detection.
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      sel_n_d <= 1'b1;
    end else begin
      sclk_d  <= sclk_s;
      sel_n_d <= sel_n_s;
    end
  end

  assign shift_en = sclk_s & ~sclk_d & ~sel_n_s;
  assign load_o   = sel_n_s & ~sel_n_d;

  // Frame register: preset leaves it untouched.
  always_ff @(posedge clk) begin
    if (rst)           sreg <= '0;
    else if (shift_en) sreg <= {sreg[FRAME_W-2:0], dat_s};
  end

  // Daisy-chain stage: takes the bit falling off the top of the register.
  always_ff @(posedge clk) begin
    if (rst)           stage_q <= 1'b0;
    else if (pre_act)  stage_q <= 1'b0;
    else if (shift_en) stage_q <= sreg[FRAME_W-1];
  end

  assign frame_o = sreg;
  assign sdat_o  = shdn_act | stage_q;

endmodule

// File: rtl/scl_latch_bank.sv
module scl_latch_bank #(
  parameter int NCH    = 6,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int FRAME_W = ADDR_W + DATA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load_i,
  input  logic [FRAME_W-1:0]    frame_i,
  input  logic                  pre_act,
  input  logic                  shdn_req,
  output logic [NCH*DATA_W-1:0] code_o,
  output logic [NCH-1:0]        shdn_o
);

  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;

  assign addr = frame_i[FRAME_W-1:DATA_W];
  assign data = frame_i[DATA_W-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              hit;
    logic [DATA_W-1:0] code_q;
    logic              off_q;

    assign hit = load_i && (addr == ADDR_W'(c));

    always_ff @(posedge clk) begin
      if (rst || pre_act) code_q <= MID;
      else if (hit)       code_q <= data;
    end

    always_ff @(posedge clk) begin
      if (rst) off_q <= 1'b0;
      else     off_q <= shdn_req;
    end

    assign code_o[c*DATA_W +: DATA_W] = code_q;
    assign shdn_o[c]                  = off_q;
  end

endmodule

// File: rtl/serial_code_latch_bank.sv
module serial_code_latch_bank
  import scl_pkg::*;
#(
  parameter int NCH         = 6,
  parameter int ADDR_W      = ADDR_W_DEF,
  parameter int DATA_W      = DATA_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk_i,
  input  logic                  sel_n_i,
  input  logic                  sdat_i,
  input  logic                  preset_n_i,
  input  logic                  shdn_n_i,
  output logic [NCH*DATA_W-1:0] code_o,
  output logic [NCH-1:0]        shdn_o,
  output logic                  sdat_o
);

  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int PIN_W   = $bits(pins_t);

  pins_t              pins_raw;
  pins_t              pins_s;
  logic [PIN_W-1:0]   pins_vec;
  logic               pre_act_w;
  logic               shdn_act_q;
  logic               load_w;
  logic [FRAME_W-1:0] frame_w;

  assign pins_raw = '{preset_n: preset_n_i, shdn_n: shdn_n_i, sel_n: sel_n_i,
                      sclk: sclk_i, dat: sdat_i};

  scl_pin_sync #(
    .W      (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) i_sync (
    .clk(clk),
    .rst(rst),
    .d_i(pins_raw),
    .q_o(pins_vec)
  );

  assign pins_s    = pins_vec;
  assign pre_act_w = ~pins_s.preset_n;

  // Registered shutdown level that gates the serial output.
  always_ff @(posedge clk) begin
    if (rst) shdn_act_q <= 1'b0;
    else     shdn_act_q <= ~pins_s.shdn_n;
  end

  scl_shift_front #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_front (
    .clk     (clk),
    .rst     (rst),
    .sclk_s  (pins_s.sclk),
    .sel_n_s (pins_s.sel_n),
    .dat_s   (pins_s.dat),
    .pre_act (pre_act_w),
    .shdn_act(shdn_act_q),
    .load_o  (load_w),
    .frame_o (frame_w),
    .sdat_o  (sdat_o)
  );

  scl_latch_bank #(
    .NCH   (NCH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_bank (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_w),
    .frame_i (frame_w),
    .pre_act (pre_act_w),
    .shdn_req(~pins_s.shdn_n),
    .code_o  (code_o),
    .shdn_o  (shdn_o)
  );

endmodule

// File: rtl/scl_checker.sv
module scl_checker #(
  parameter int NCH    = 6,
  parameter int DATA_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NCH*DATA_W-1:0] code_o,
  input logic [NCH-1:0]        shdn_o,
  input logic                  sdat_o,
  input logic                  load_evt,
  input logic                  pre_act
);

  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  logic [NCH*DATA_W-1:0] prev_code;
  logic [NCH-1:0]        chg;

  always_ff @(posedge clk) prev_code <= code_o;

  for (genvar c = 0; c < NCH; c++) begin : g_chg
    assign chg[c] = code_o[c*DATA_W +: DATA_W] != prev_code[c*DATA_W +: DATA_W];
  end

  // R1
  reset_mid_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (code_o == {NCH{MID}}) && (shdn_o == '0) && !sdat_o);

  // R3
  single_update_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(pre_act) |-> $countones(chg) <= 1);

  // R4
  hold_without_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_evt && !pre_act) |=> $stable(code_o));

  // R8
  preset_mid_chk: assert property (@(posedge clk) disable iff (rst)
    pre_act |=> (code_o == {NCH{MID}}) && (sdat_o == shdn_o[0]));

  // R9
  shutdown_out_chk: assert property (@(posedge clk) disable iff (rst)
    (shdn_o != '0) |-> (shdn_o == '1) && sdat_o);

endmodule

bind serial_code_latch_bank scl_checker #(
  .NCH   (NCH),
  .DATA_W(DATA_W)
) i_chk (
  .clk     (clk),
  .rst     (rst),
  .code_o  (code_o),
  .shdn_o  (shdn_o),
  .sdat_o  (sdat_o),
  .load_evt(load_w),
  .pre_act (pre_act_w)
);

// File: tb/test_serial_code_latch_bank.sv
module test_serial_code_latch_bank;

  localparam int NCH = 6;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sel_n = 1'b1, sdat = 1'b0, preset_n = 1'b1, shdn_n = 1'b1;
  logic [NCH*DW-1:0] code_o;
  logic [NCH-1:0]    shdn_o;
  logic              sdat_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic smp_q[$];

  always #2 clk = ~clk;

  serial_code_latch_bank #(.NCH(NCH)) i_serial_code_latch_bank (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sel_n_i(sel_n), .sdat_i(sdat),
    .preset_n_i(preset_n), .shdn_n_i(shdn_n),
    .code_o(code_o), .shdn_o(shdn_o), .sdat_o(sdat_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ch(input int c);
    return code_o[c*DW +: DW];
  endfunction

  // ---------------- reference model ----------------
  // Pin samples are kept as {preset_n, shdn_n, sel_n, sclk, dat}.
  logic [4:0] h1, h2, h3;
  logic [7:0] m_code [NCH];
  logic [10:0] m_sr;
  logic m_stage, m_off;

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) m_code[c] = 8'h80;
      m_sr = '0; m_stage = 0; m_off = 0;
      h1 = 5'b11100; h2 = 5'b11100; h3 = 5'b11100;
    end else begin
      bit pre, shf, ld;
      pre = !h2[4];
      shf = h2[1] && !h3[1] && !h2[2];
      ld  = h2[2] && !h3[2];
      if (pre) begin
        for (int c = 0; c < NCH; c++) m_code[c] = 8'h80;
      end else if (ld && int'(m_sr[10:8]) < NCH) begin
        m_code[m_sr[10:8]] = m_sr[7:0];
      end
      if (pre)      m_stage = 0;
      else if (shf) m_stage = m_sr[10];
      if (shf) m_sr = {m_sr[9:0], h2[0]};
      m_off = !h2[3];
      h3 = h2; h2 = h1;
    end
    h1 = {preset_n, shdn_n, sel_n, sclk, sdat};
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int c = 0; c < NCH; c++) chk("R3 model code", 64'(ch(c)), 64'(m_code[c]));
      chk("R9 model flags", 64'(shdn_o), m_off ? 64'h3F : 64'h0);
      chk("R7 model serial out", 64'(sdat_o), 64'(m_off | m_stage));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    sdat = b;
    wait_n(2);
    sclk = 1'b1;
    wait_n(4);
    smp_q.push_back(sdat_o);
    sclk = 1'b0;
    wait_n(4);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) sbit(w[i]);
  endtask

  task automatic frame(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    sel_n = 1'b0;
    wait_n(4);
    send_bits({21'd0, a, d}, 11);
    sel_n = 1'b1;
    wait_n(6);
  endtask

  task automatic sel_pulse();
    @(negedge clk);
    sel_n = 1'b0;
    wait_n(4);
    sel_n = 1'b1;
    wait_n(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [10:0] fa;
    wait_n(5);
    rst = 1'b0;
    wait_n(2);
    // R1 reset state
    for (int c = 0; c < NCH; c++) chk("R1 reset code", 64'(ch(c)), 64'h80);
    chk("R1 reset flags", 64'(shdn_o), 64'h0);
    chk("R1 reset serial out", 64'(sdat_o), 64'h0);

    // R2 R3 basic frames
    frame(3'd2, 8'h3C);
    chk("R2 channel 2 code", 64'(ch(2)), 64'h3C);
    chk("R3 channel 1 untouched", 64'(ch(1)), 64'h80);
    frame(3'd0, 8'hFF);
    chk("R3 channel 0 code", 64'(ch(0)), 64'hFF);
    // R4 top channel and ignored addresses
    frame(3'd5, 8'h01);
    chk("R4 channel 5 code", 64'(ch(5)), 64'h01);
    frame(3'd6, 8'hAA);
    frame(3'd7, 8'h55);
    chk("R4 addr 6/7 ignored ch0", 64'(ch(0)), 64'hFF);
    chk("R4 addr 6/7 ignored ch5", 64'(ch(5)), 64'h01);
    chk("R4 addr 6/7 ignored ch3", 64'(ch(3)), 64'h80);

    // R5 clocks with select high do not shift
    frame(3'd1, 8'h11);
    for (int i = 0; i < 11; i++) sbit(1'b0);
    sel_pulse();
    chk("R5 ch0 kept after idle clocks", 64'(ch(0)), 64'hFF);
    chk("R5 ch1 reloaded", 64'(ch(1)), 64'h11);

    // R6 short frame: 4 bits 1010 on top of {001,0x11} gives {001,0x1A}
    @(negedge clk); sel_n = 1'b0; wait_n(4);
    send_bits(32'hA, 4);
    sel_n = 1'b1; wait_n(6);
    chk("R6 short frame ch1", 64'(ch(1)), 64'h1A);

    // R7 daisy chain, 22 bits with select low throughout
    fa = {3'd3, 8'h5A};
    smp_q.delete();
    @(negedge clk); sel_n = 1'b0; wait_n(4);
    send_bits({21'd0, fa}, 11);
    send_bits({21'd0, 3'd4, 8'hC3}, 11);
    sel_n = 1'b1; wait_n(6);
    for (int i = 0; i < 11; i++) chk("R7 delayed serial bit", 64'(smp_q[11+i]), 64'(fa[10-i]));
    chk("R7 chained frame to ch4", 64'(ch(4)), 64'hC3);
    chk("R7 first frame not loaded ch3", 64'(ch(3)), 64'h80);

    // R8 preset, register retained, priority over load
    preset_n = 1'b0; wait_n(5);
    chk("R8 preset ch4", 64'(ch(4)), 64'h80);
    chk("R8 preset ch0", 64'(ch(0)), 64'h80);
    chk("R8 preset serial out", 64'(sdat_o), 64'h0);
    preset_n = 1'b1; wait_n(4);
    sel_pulse();
    chk("R8 shift register kept", 64'(ch(4)), 64'hC3);
    sel_n = 1'b0; wait_n(4);
    sel_n = 1'b1; preset_n = 1'b0;
    wait_n(3);
    preset_n = 1'b1; wait_n(6);
    chk("R8 preset beats load", 64'(ch(4)), 64'h80);

    // R9 shutdown keeps codes
    frame(3'd2, 8'h77);
    shdn_n = 1'b0; wait_n(5);
    chk("R9 flags set", 64'(shdn_o), 64'h3F);
    chk("R9 serial out forced", 64'(sdat_o), 64'h1);
    chk("R9 code kept", 64'(ch(2)), 64'h77);
    shdn_n = 1'b1; wait_n(5);
    chk("R9 flags clear", 64'(shdn_o), 64'h0);
    chk("R9 code after release", 64'(ch(2)), 64'h77);

    // R10 load latency: third rising edge after select rises
    @(negedge clk); sel_n = 1'b0; wait_n(4);
    send_bits({21'd0, 3'd0, 8'h42}, 11);
    sel_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R10 not yet loaded", 64'(ch(0)), 64'h80);
    @(posedge clk); @(negedge clk);
    chk("R10 loaded on third edge", 64'(ch(0)), 64'h42);
    wait_n(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule